// File: doc/BRIEF.md
# Dual-Resolution Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter that can resolve either 12 or 8 bits. It accepts a convert request and then runs a fixed sequence of phases. The comparator is purged first, then auto-zeroed, then the input is sampled, and then one bit is resolved per clock cycle. During the bit cycles it drives a 12-bit trial word to a capacitive DAC that is split into two 6-bit halves. It reads the comparator decision once per bit cycle.

Between conversions the block holds the comparator asleep. A separate stage-disable output switches off the comparator stages that are only needed for 12-bit accuracy. That output is active while idle and throughout an 8-bit conversion. When the last bit is decided, the code appears on the result output together with a one-cycle done pulse. The code stays there until the next conversion completes.

Top module: `sar_seq`

## Requirements
- R1: A conversion occupies its cycles in the fixed order: purge, auto-zero, sample, bit cycles. Exactly one of the purge, azero and sample strobes is high in each of the first three phases. None of them is high during bit cycles, while busy stays high.
- R2: With mode8 low at the accepted request, busy stays high for 17 cycles: 1 purge, 3 auto-zero, 1 sample and 12 bit cycles.
- R3: With mode8 high at the accepted request, busy stays high for 12 cycles: 1 purge, 2 auto-zero, 1 sample and 8 bit cycles. mode8 is sampled only when a request is accepted.
- R4: Bits are resolved MSB first. Each bit cycle sets the current trial bit on the DAC word {dac_hi, dac_lo}, where dac_hi carries bits 11..6 and dac_lo bits 5..0. The bit is kept when cmp_out is 1 and cleared when cmp_out is 0. With a comparator reporting vin >= DAC word, a 12-bit result equals vin.
- R5: In 8-bit mode the code occupies result[11:4] and result[3:0] is zero. With the comparator above, the result equals vin with its low four bits cleared.
- R6: done is high for exactly one cycle: the first cycle in which busy is low after a conversion. result changes only at that edge and holds its value afterwards.
- R7: A start pulse that arrives while busy is ignored. The running conversion keeps its length, and no second conversion follows it.
- R8: While sleep_in is high, start is ignored and the block stays idle.
- R9: cmp_sleep is high exactly when busy is low.
- R10: hires_off is high while idle and during an 8-bit conversion. It is low during a 12-bit conversion.
- R11: After reset the block is idle: busy, done and the three strobes are low, result is zero, and cmp_sleep and hires_off are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_in | input | 1 | Blocks new conversions while high |
| start | input | 1 | Convert request, sampled while idle |
| mode8 | input | 1 | 1 selects 8-bit conversion, 0 selects 12-bit |
| cmp_out | input | 1 | Comparator decision for the current trial word |
| purge | output | 1 | Comparator purge strobe |
| azero | output | 1 | Comparator auto-zero strobe |
| sample | output | 1 | Input sampling strobe |
| dac_hi | output | 6 | Trial word bits 11..6 to the main DAC half |
| dac_lo | output | 6 | Trial word bits 5..0 to the sub DAC half |
| cmp_sleep | output | 1 | Comparator sleep, high when idle |
| hires_off | output | 1 | Disables the comparator stages used only at 12 bits |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 12 | Converted code |

## Verification
The hardest situation to reach is a convert request landing in the middle of a running conversion. It must be shown to neither restart nor stretch the sequence, nor queue a second one. The stimulus raises start for one cycle inside the bit phase of a conversion. It then times busy cycle by cycle and watches for three further cycles that no second conversion begins. The comparator is modelled from a held input value, so the resolved code can be predicted for endpoint inputs (all zeros, all ones, mid-scale and its neighbour) and for 8-bit truncation.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int HALF  = 6,
  parameter int AZ_HI = 3,
  parameter int AZ_LO = 2,
  parameter int BITS8 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_in,
  input  logic              start,
  input  logic              mode8,
  input  logic              cmp_out,
  output logic              purge,
  output logic              azero,
  output logic              sample,
  output logic [HALF-1:0]   dac_hi,
  output logic [HALF-1:0]   dac_lo,
  output logic              cmp_sleep,
  output logic              hires_off,
  output logic              busy,
  output logic              done,
  output logic [2*HALF-1:0] result
);
  localparam int W     = 2 * HALF;
  localparam int IW    = $clog2(W);
  localparam int LAST8 = W - BITS8;

  typedef enum logic [2:0] {S_IDLE, S_PURGE, S_AZ, S_SMPL, S_BIT} st_t;

  st_t          st;
  logic         m8;
  logic [2:0]   azc;
  logic [IW-1:0] idx;
  logic [W-1:0] code;
  logic [W-1:0] code_k;
  logic [IW-1:0] last_idx;

  assign code_k   = cmp_out ? code : (code & ~(W'(1) << idx));
  assign last_idx = m8 ? IW'(LAST8) : '0;

  assign purge     = (st == S_PURGE);
  assign azero     = (st == S_AZ);
  assign sample    = (st == S_SMPL);
  assign busy      = (st != S_IDLE);
  assign cmp_sleep = !busy;
  assign hires_off = !busy || m8;
  assign dac_hi    = code[W-1:HALF];
  assign dac_lo    = code[HALF-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      m8     <= 1'b0;
      azc    <= '0;
      idx    <= '0;
      code   <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start && !sleep_in) begin
          m8 <= mode8;
          st <= S_PURGE;
        end
        S_PURGE: begin
          azc <= m8 ? 3'(AZ_LO - 1) : 3'(AZ_HI - 1);
          st  <= S_AZ;
        end
        S_AZ: begin
          if (azc == '0) st <= S_SMPL;
          else azc <= azc - 3'd1;
        end
        S_SMPL: begin
          idx  <= IW'(W - 1);
          code <= W'(1) << (W - 1);
          st   <= S_BIT;
        end
        S_BIT: begin
          if (idx == last_idx) begin
            result <= code_k;
            done   <= 1'b1;
            code   <= '0;
            st     <= S_IDLE;
          end else begin
            code <= code_k | (W'(1) << (idx - IW'(1)));
            idx  <= idx - IW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sar_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        purge,
  input logic        azero,
  input logic        sample,
  input logic        busy,
  input logic        done,
  input logic        cmp_sleep,
  input logic        hires_off,
  input logic [11:0] result
);
  logic [4:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (!busy) run <= '0;
    else run <= run + 5'd1;

  // R1
  purge_then_az_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> azero);
  // R1
  sample_then_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (busy && !purge && !azero && !sample));
  // R2
  len12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(hires_off)) |-> (run == 5'd17));
  // R3
  len8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(hires_off)) |-> (run == 5'd12));
  // R5
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(hires_off)) |-> (result[3:0] == 4'd0));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R7
  purge_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge |-> !$past(busy));
  // R9
  sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_sleep == !busy);
  // R10
  hires_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> hires_off);
endmodule

bind sar_seq sar_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .purge(purge), .azero(azero), .sample(sample),
  .busy(busy), .done(done), .cmp_sleep(cmp_sleep), .hires_off(hires_off),
  .result(result)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_in = 1'b0, start = 1'b0, mode8 = 1'b0;
  logic cmp_out;
  logic purge, azero, sample, cmp_sleep, hires_off, busy, done;
  logic [5:0] dac_hi, dac_lo;
  logic [11:0] result;
  logic [11:0] vin = '0, vin_hold = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sar_seq uut (
    .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .start(start), .mode8(mode8),
    .cmp_out(cmp_out), .purge(purge), .azero(azero), .sample(sample),
    .dac_hi(dac_hi), .dac_lo(dac_lo), .cmp_sleep(cmp_sleep), .hires_off(hires_off),
    .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) if (sample) vin_hold <= vin;
  assign cmp_out = (vin_hold >= {dac_hi, dac_lo});

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [11:0] v, input bit m8, input bit poke,
                          input string req);
    int az, n, ph, eph, bad_ph, bad_sl, bad_hr;
    logic [11:0] exp;
    az = m8 ? 2 : 3;
    exp = m8 ? (v & 12'hFF0) : v;
    bad_ph = 0; bad_sl = 0; bad_hr = 0; n = 0;
    @(negedge clk);
    vin = v; mode8 = m8; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode8 = ~m8;
    while (busy && n < 40) begin
      ph = purge ? 0 : azero ? 1 : sample ? 2 : 3;
      eph = (n == 0) ? 0 : (n <= az) ? 1 : (n == az + 1) ? 2 : 3;
      if (ph != eph || (purge + azero + sample) > 1) bad_ph++;
      if (cmp_sleep) bad_sl++;
      if (hires_off != m8) bad_hr++;
      start = (poke && n == 8);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(bad_ph == 0, "R1 phase order", bad_ph, 0);
    chk(n == (m8 ? 12 : 17), m8 ? "R3 length" : "R2 length", n, m8 ? 12 : 17);
    chk(bad_sl == 0, "R9 awake while busy", bad_sl, 0);
    chk(bad_hr == 0, "R10 stage disable", bad_hr, 0);
    chk(done == 1'b1, "R6 done with idle", done, 1);
    chk(result == exp, m8 ? "R5 8-bit code" : req, result, exp);
    @(negedge clk);
    chk(done == 1'b0 && result == exp, "R6 single pulse and hold", done, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !purge && !azero && !sample, "R11 idle", busy, 0);
    chk(result == 12'd0, "R11 result", result, 0);
    chk(cmp_sleep && hires_off, "R11 sleeps", {cmp_sleep, hires_off}, 3);
  endtask

  task automatic t_conv12();
    run_conv(12'd0, 1'b0, 1'b0, "R4 zero");
    run_conv(12'hFFF, 1'b0, 1'b0, "R4 full");
    run_conv(12'h800, 1'b0, 1'b0, "R4 mid");
    run_conv(12'h7FF, 1'b0, 1'b0, "R4 below mid");
    run_conv(12'hA5C, 1'b0, 1'b0, "R4 pattern");
  endtask

  task automatic t_conv8();
    run_conv(12'hFFF, 1'b1, 1'b0, "R5");
    run_conv(12'h5A7, 1'b1, 1'b0, "R5");
    run_conv(12'h00F, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_busy_ignore();
    int extra;
    run_conv(12'h3C1, 1'b0, 1'b1, "R7 poked conversion");
    extra = 0;
    for (int i = 0; i < 3; i++) begin
      if (busy || done) extra++;
      @(negedge clk);
    end
    chk(extra == 0, "R7 no second conversion", extra, 0);
  endtask

  task automatic t_sleep();
    int act;
    logic [11:0] prev;
    prev = result;
    act = 0;
    @(negedge clk);
    sleep_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (busy || purge || done) act++;
      @(negedge clk);
    end
    sleep_in = 1'b0;
    chk(act == 0 && result == prev, "R8 start blocked", act, 0);
    chk(cmp_sleep, "R9 asleep idle", cmp_sleep, 1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conv12();
    t_conv8();
    t_busy_ignore();
    t_sleep();
    run_conv(12'h123, 1'b0, 1'b0, "R4 after sleep");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule